// File: doc/BRIEF.md
# Floating-Point Widening Converter

This block turns a binary floating-point value of either 32-bit or 64-bit width into the 80-bit extended format. In that format the leading integer bit of the significand is stored, not implied. A format select line picks which input layout is decoded. For ordinary values the converter re-biases the exponent into the 15-bit extended range and writes out the hidden one as an explicit bit. It widens the fraction exactly, so no rounding is needed.

Zero, infinity and NaN inputs are mapped to their extended encodings. A NaN always leaves the block as a quiet NaN. Subnormal inputs are not supported: they come out as a zero with the input's sign, and a flag marks them. Input is taken with a valid/ready handshake. The result is registered and appears one clock after it is accepted.

Top module: `fp_widen`

## Requirements
- R1: While `rst` is high, `in_ready`, `out_valid` and `out_denorm` read 0 and `out_bits` reads all zeros.
- R2: Out of reset `in_ready` is 1. An input is accepted in any cycle where `in_valid` and `in_ready` are both high, and `out_valid` is 1 in the cycle after an accepted input and 0 otherwise. While no input is accepted, `out_bits` keeps its last value.
- R3: With `in_dbl`=0, `in_bits[31]` is the sign, `[30:23]` the exponent and `[22:0]` the fraction, and `in_bits[63:32]` has no effect. With `in_dbl`=1, `[63]` is the sign, `[62:52]` the exponent and `[51:0]` the fraction. In `out_bits`, `[79]` is the sign, `[78:64]` the exponent and `[63:0]` the significand, with `[63]` as the explicit integer bit. The output sign always equals the input sign.
- R4: For a 32-bit normal input, the output exponent is the input exponent plus 0x3F80 and the significand is {1, fraction, 40 zero bits}. For example, 0x42C88000 gives 80'h4005_C880_0000_0000_0000.
- R5: For a 64-bit normal input, the output exponent is the input exponent plus 0x3C00 and the significand is {1, fraction, 11 zero bits}.
- R6: An input with a zero exponent and a zero fraction gives a signed zero: exponent 0, significand 0, and `out_denorm` 0.
- R7: An input with an all-ones exponent and a zero fraction gives infinity: exponent 0x7FFF and significand 0x8000_0000_0000_0000.
- R8: An input with an all-ones exponent and a nonzero fraction gives exponent 0x7FFF. Its significand has bit 63 set, the fraction left-aligned directly below bit 63 and zero-filled, and bit 62 forced to 1.
- R9: An input with a zero exponent and a nonzero fraction gives a signed zero with `out_denorm` = 1, in the output cycle of that result only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter can take an input |
| in_dbl | input | 1 | 1 selects the 64-bit layout, 0 the 32-bit layout |
| in_bits | input | 64 | Input value (32-bit layout uses bits 31:0) |
| out_valid | output | 1 | Result present this cycle |
| out_bits | output | 80 | Extended result: sign, 15-bit exponent, 64-bit significand |
| out_denorm | output | 1 | Result came from a subnormal input |

## Verification
The bench checks the exponent boundaries of both layouts: the smallest and largest normal values, zeros of both signs, infinities, and signalling NaNs whose payload has only the lowest bit set. If the wrong bias offset were used, every normal result would be shifted by a constant. If the quiet bit were dropped, a low-payload NaN would come out as a signalling NaN. If the explicit one were left off, infinity would read as a pseudo-infinity. The 32-bit inputs carry random upper halves, so that any leak of those bits into the result is caught. Subnormals of both signs are sent back to back with normal values, which catches a flag that stays high into the next result.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    localparam int XP_EXP_W  = 15;
    localparam int XP_SIG_W  = 64;
    localparam int XP_FRAC_W = XP_SIG_W - 1;
    localparam int XP_BIAS   = 16383;
    localparam int XP_W      = 1 + XP_EXP_W + XP_SIG_W;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = 127;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;

    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_BIAS   = 1023;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;

    typedef enum logic [2:0] {
        FC_ZERO,
        FC_SUB,
        FC_NORM,
        FC_INF,
        FC_NAN
    } fclass_e;

    typedef struct packed {
        logic                 sign;
        fclass_e              cls;
        logic [XP_EXP_W-1:0]  exp;
        logic [XP_FRAC_W-1:0] frac;
    } wide_fields_t;

    typedef struct packed {
        logic                sign;
        logic [XP_EXP_W-1:0] exp;
        logic [XP_SIG_W-1:0] sig;
    } xp_word_t;

    function automatic logic [XP_EXP_W-1:0] rebias(input logic [XP_EXP_W-1:0] e,
                                                   input int src_bias);
        return e + XP_EXP_W'(XP_BIAS - src_bias);
    endfunction

endpackage

// File: rtl/fpw_unpack.sv
module fpw_unpack
    import fpw_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int BIAS   = 127
) (
    input  logic [EXP_W+FRAC_W:0] raw,
    output wide_fields_t          fields
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int PAD_W = XP_FRAC_W - FRAC_W;

    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    logic              e_max, e_zero, f_zero;

    assign e      = raw[W-2 -: EXP_W];
    assign f      = raw[FRAC_W-1:0];
    assign e_max  = &e;
    assign e_zero = ~|e;
    assign f_zero = ~|f;

    always_comb begin
        fields.sign = raw[W-1];
        fields.exp  = rebias(XP_EXP_W'(e), BIAS);
        fields.frac = {f, {PAD_W{1'b0}}};
        if (e_max)
            fields.cls = f_zero ? FC_INF : FC_NAN;
        else if (e_zero)
            fields.cls = f_zero ? FC_ZERO : FC_SUB;
        else
            fields.cls = FC_NORM;
    end

endmodule

// File: rtl/fpw_pack.sv
module fpw_pack
    import fpw_pkg::*;
(
    input  wide_fields_t fields,
    output xp_word_t     word,
    output logic         denorm
);
    localparam logic [XP_EXP_W-1:0] EXP_ALL1 = '1;

    always_comb begin
        word.sign = fields.sign;
        word.exp  = '0;
        word.sig  = '0;
        denorm    = 1'b0;
        unique case (fields.cls)
            FC_NORM: begin
                word.exp = fields.exp;
                word.sig = {1'b1, fields.frac};
            end
            FC_INF: begin
                word.exp = EXP_ALL1;
                word.sig = {1'b1, {XP_FRAC_W{1'b0}}};
            end
            FC_NAN: begin
                word.exp = EXP_ALL1;
                word.sig = {2'b11, fields.frac[XP_FRAC_W-2:0]};
            end
            FC_SUB: begin
                denorm = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fp_widen.sv
module fp_widen
    import fpw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_dbl,
    input  logic [DP_W-1:0] in_bits,
    output logic            out_valid,
    output logic [XP_W-1:0] out_bits,
    output logic            out_denorm
);
    wide_fields_t sp_f, dp_f, sel_f;
    xp_word_t     word_d, word_q;
    logic         den_d, den_q, valid_q, accept;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    fpw_unpack #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .BIAS(SP_BIAS)) u_sp (
        .raw    (in_bits[SP_W-1:0]),
        .fields (sp_f)
    );

    fpw_unpack #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .BIAS(DP_BIAS)) u_dp (
        .raw    (in_bits),
        .fields (dp_f)
    );

    assign sel_f = in_dbl ? dp_f : sp_f;

    fpw_pack u_pack (
        .fields (sel_f),
        .word   (word_d),
        .denorm (den_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            den_q   <= 1'b0;
        end else begin
            valid_q <= accept;
            den_q   <= accept & den_d;
            if (accept)
                word_q <= word_d;
        end
    end

    assign out_valid  = valid_q;
    assign out_bits   = word_q;
    assign out_denorm = den_q;

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!out_valid && !out_denorm && $stable(out_bits)));
    p_sign_kept_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_bits[XP_W-1] == $past(in_dbl ? in_bits[DP_W-1] : in_bits[SP_W-1]));
    p_explicit_one_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (|out_bits[XP_W-2 -: XP_EXP_W])) |-> out_bits[XP_SIG_W-1]);
    p_zero_sig_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(|out_bits[XP_W-2 -: XP_EXP_W])) |-> out_bits[XP_SIG_W-1:0] == '0);
    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (&out_bits[XP_W-2 -: XP_EXP_W]) && (|out_bits[XP_SIG_W-2:0]))
            |-> out_bits[XP_SIG_W-2]);
    p_denorm_zero_r9: assert property (@(posedge clk) disable iff (rst)
        out_denorm |-> (out_valid && out_bits[XP_W-2:0] == '0));

endmodule

// File: tb/fp_widen_test.sv
module fp_widen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [63:0] in_bits = '0;
    logic        in_ready, out_valid, out_denorm;
    logic [79:0] out_bits;

    int checks = 0;
    int fails  = 0;
    logic [80:0] exp_q[$];
    string       tag_q[$];
    logic [79:0] last_bits = '0;

    always #2 clk = ~clk;

    fp_widen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dbl(in_dbl), .in_bits(in_bits), .out_valid(out_valid),
        .out_bits(out_bits), .out_denorm(out_denorm)
    );

    function automatic logic [80:0] model(input logic dbl, input logic [63:0] b);
        logic        s;
        int          e, bias, emax;
        logic [63:0] fa;
        if (dbl) begin
            s = b[63]; e = int'(b[62:52]); emax = 2047; bias = 1023;
            fa = {b[51:0], 12'b0};
        end else begin
            s = b[31]; e = int'(b[30:23]); emax = 255; bias = 127;
            fa = {b[22:0], 41'b0};
        end
        if (e == emax) begin
            if (fa == 0) return {1'b0, s, 15'h7FFF, 64'h8000_0000_0000_0000};
            return {1'b0, s, 15'h7FFF, 1'b1, fa[63:1] | 63'h4000_0000_0000_0000};
        end
        if (e == 0) return {(fa != 0), s, 79'b0};
        return {1'b0, s, 15'(e - bias + 16383), 1'b1, fa[63:1]};
    endfunction

    task automatic check(input string tag, input logic [80:0] got, input logic [80:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic send(input string tag, input logic dbl, input logic [63:0] b);
        in_valid = 1'b1;
        in_dbl   = dbl;
        in_bits  = b;
        exp_q.push_back(model(dbl, b));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 81'd1, 81'd0);
            end else begin
                logic [80:0] want;
                string       t;
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                check(t, {out_denorm, out_bits}, want);
                last_bits = out_bits;
            end
        end
    end

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", {in_ready, out_valid, out_denorm, out_bits}, 83'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 ready after reset", {80'd0, in_ready}, {80'd0, 1'b1});

        send("R4 single 100.25", 1'b0, 64'hDEAD_BEEF_42C8_8000);
        @(negedge clk);
        check("R4 worked value", {1'b0, last_bits}, {1'b0, 80'h4005_C880_0000_0000_0000});
        @(negedge clk);
        check("R2 idle hold", {out_valid, out_bits}, {1'b0, 80'h4005_C880_0000_0000_0000});

        send("R3 upper half ignored", 1'b0, 64'hFFFF_FFFF_3F80_0000);
        send("R4 min normal", 1'b0, 64'h0000_0000_0080_0000);
        send("R4 max normal", 1'b0, 64'h0000_0000_FF7F_FFFF);
        send("R6 plus zero", 1'b0, 64'h1234_5678_0000_0000);
        send("R6 minus zero", 1'b0, 64'h0000_0000_8000_0000);
        send("R7 plus inf", 1'b0, 64'h0000_0000_7F80_0000);
        send("R7 minus inf", 1'b0, 64'h0000_0000_FF80_0000);
        send("R8 signalling NaN", 1'b0, 64'h0000_0000_7F80_0001);
        send("R8 quiet NaN", 1'b0, 64'h0000_0000_FFC0_0000);
        send("R9 subnormal low", 1'b0, 64'h0000_0000_0000_0001);
        send("R9 flag clears", 1'b0, 64'h0000_0000_3F80_0000);
        send("R9 neg subnormal", 1'b0, 64'h0000_0000_807F_FFFF);
        send("R5 double 100.25", 1'b1, 64'h4059_1000_0000_0000);
        send("R5 double min normal", 1'b1, 64'h0010_0000_0000_0000);
        send("R5 double max normal", 1'b1, 64'hFFEF_FFFF_FFFF_FFFF);
        send("R6 double minus zero", 1'b1, 64'h8000_0000_0000_0000);
        send("R7 double inf", 1'b1, 64'h7FF0_0000_0000_0000);
        send("R8 double NaN", 1'b1, 64'h7FF0_0000_0000_0001);
        send("R9 double subnormal", 1'b1, 64'h8000_0000_0000_0001);
        @(negedge clk);
        @(negedge clk);
        check("R2 idle after burst", {80'd0, out_valid}, 81'd0);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] b;
            logic        d;
            int          k;
            b = {$urandom, $urandom};
            d = 1'(i % 2);
            k = int'($urandom % 8);
            if (k == 0) begin
                if (d) b[62:52] = '0; else b[30:23] = '0;
            end else if (k == 1) begin
                if (d) b[62:52] = '1; else b[30:23] = '1;
            end
            send(d ? "R5 random double" : "R3 R4 random single", d, b);
            if ($urandom % 4 == 0) @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
        check("R2 all results seen", {80'd0, exp_q.size() == 0}, 81'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule